// File: doc/BRIEF.md
# Half-Cycle Interleaved Memory Arbiter

This block lets a CPU-side bus and a video-fetch bus share one single-port SRAM without either master ever waiting. Each system clock cycle is cut into two slots on a fast clock. The video reader owns the first slot and the CPU owns the second, so the two masters sit half a system cycle apart. Each slot has a setup step and an access step. The select for the external isolation buffers moves to the new owner in the setup step, and the memory is enabled only in the access step that follows. Each slot completes one memory access, so every system cycle carries exactly one video read and one CPU read or write. There is no stall or halt output of any kind.

The block runs on a fast clock at four times the system rate and flags the start of each system cycle on `cycle_start`. Masters present a request together with its address, and write data where needed, at the start of a system cycle and hold it for that whole cycle. Read results go into one holding register per master. Each register is loaded at the end of its master's access step and holds that value until the same master's next read completes. The video port has no write path.

Top module: `halfslot_mem_arb`

## Requirements
- R1: While reset is asserted, `bus_owner` is 0, `mem_we`, `mem_oe` and `cycle_start` are 0, and both holding registers read 0. After reset is released, the first slot is a CPU slot. `cycle_start` first goes high on the 4th fast cycle after release, and `bus_owner` stays 0 until then.
- R2: The fast-cycle sequence repeats with period 4: video setup (where `cycle_start` is 1), video access, CPU setup, CPU access. `cycle_start` is high in exactly one fast cycle of every four.
- R3: `bus_owner` (0 = CPU, 1 = video) changes only on entry to a setup step. `mem_we` and `mem_oe` are asserted only in an access step, with `bus_owner` unchanged from the preceding setup step.
- R4: `mem_we` is 1 only in the CPU access step of a cycle where `cpu_req`=1 and `cpu_we`=1, with `mem_addr`/`mem_wdata` equal to `cpu_addr`/`cpu_wdata`. It is never 1 while `bus_owner`=1.
- R5: `mem_oe` is 1 in the video access step when `vid_req`=1, and in the CPU access step when `cpu_req`=1 and `cpu_we`=0. `mem_oe` and `mem_we` are never both 1.
- R6: The video read issued in a cycle returns memory contents from before that cycle's CPU write. A write to the same address in cycle N is therefore seen by a video read in cycle N+1 but not in cycle N.
- R7: A CPU read issued in a cycle appears on `cpu_rdata` at the next `cycle_start`.
- R8: A holding register changes only at the end of its own master's read access. It keeps its value through cycles with no request from that master and through CPU writes.
- R9: A CPU access and a video access both complete in every system cycle, whatever the other master requests. The CPU is never delayed.
- R10: A slot whose master makes no request asserts neither `mem_oe` nor `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, four times the system cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU requests an access in this system cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read holding register |
| vid_req | input | 1 | Video port requests a read in this system cycle |
| vid_addr | input | ADDR_W | Video read address |
| vid_rdata | output | DATA_W | Video read holding register |
| cycle_start | output | 1 | High during the first fast cycle of each system cycle |
| bus_owner | output | 1 | Isolation buffer select: 0 CPU, 1 video |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_oe | output | 1 | SRAM output enable |
| mem_rdata | input | DATA_W | SRAM read data |

## Verification
The hardest case to reach is a CPU write and a video read that hit the same address in the same system cycle, because the correct result depends entirely on the video slot coming first. The bench produces this case by driving both requests together at a `cycle_start`. It checks for the old value on `vid_rdata` in that cycle, then repeats the video read alone and checks for the new value. A negedge monitor runs through all scenarios. It watches for an enable while the bus owner is changing, a write while the video side owns the bus, and write and output enables asserted together.

// File: rtl/halfslot_pkg.sv
package halfslot_pkg;
  typedef enum logic {OWN_CPU = 1'b0, OWN_VID = 1'b1} owner_e;
  typedef enum logic {STEP_SETUP = 1'b0, STEP_ACCESS = 1'b1} step_e;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_CPU  = 0;
  localparam int unsigned PORT_VID  = 1;
endpackage

// File: rtl/halfslot_rst_sync.sv
module halfslot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/halfslot_seq.sv
module halfslot_seq
  import halfslot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output owner_e phase_o,
  output step_e  step_o,
  output logic   bus_owner_o,
  output logic   cycle_start_o
);
  owner_e phase_q, phase_d;
  step_e  step_q, step_d;
  logic   owner_q, owner_d;

  always_comb begin
    step_d  = (step_q == STEP_SETUP) ? STEP_ACCESS : STEP_SETUP;
    phase_d = phase_q;
    if (step_q == STEP_ACCESS) phase_d = owner_e'(~phase_q);
    owner_d = phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= OWN_CPU;
      step_q  <= STEP_SETUP;
      owner_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      owner_q <= owner_d;
    end
  end

  assign phase_o       = phase_q;
  assign step_o        = step_q;
  assign bus_owner_o   = owner_q;
  assign cycle_start_o = (phase_q == OWN_VID) && (step_q == STEP_SETUP);

  // R2
  step_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STEP_SETUP) |=> (step_q == STEP_ACCESS));
  // R2
  phase_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STEP_ACCESS) |=> (phase_q != $past(phase_q)));
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |=> !cycle_start_o);
endmodule

// File: rtl/halfslot_mem_drive.sv
module halfslot_mem_drive
  import halfslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  owner_e            phase,
  input  step_e             step,
  input  logic              bus_owner,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_oe
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d, oe_q, oe_d;
  logic              addr_en, wdata_en;

  always_comb begin
    addr_en  = (step == STEP_SETUP);
    wdata_en = 1'b0;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    we_d     = 1'b0;
    oe_d     = 1'b0;
    if (step == STEP_SETUP) begin
      if (phase == OWN_CPU) begin
        addr_d   = cpu_addr;
        we_d     = cpu_req & cpu_we;
        oe_d     = cpu_req & ~cpu_we;
        wdata_en = cpu_req & cpu_we;
        wdata_d  = cpu_wdata;
      end else begin
        addr_d = vid_addr;
        oe_d   = vid_req;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (wdata_en) wdata_q <= wdata_d;
      we_q <= we_d;
      oe_q <= oe_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
  assign mem_oe    = oe_q;

  // R4
  we_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_owner == 1'b0));
  // R5
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_oe));
  // R3
  en_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_oe) |-> (step == STEP_ACCESS));
  // R3
  sel_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_oe) |-> $stable(bus_owner));
  // R10
  vid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_SETUP && phase == OWN_VID && !vid_req) |=> !(mem_oe || mem_we));
endmodule

// File: rtl/halfslot_capture.sv
module halfslot_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (fire) hold_q <= hold_d;
  end

  assign dout = hold_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(dout));
endmodule

// File: rtl/halfslot_mem_arb.sv
module halfslot_mem_arb
  import halfslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              cycle_start,
  output logic              bus_owner,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_oe,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic   rst_int_n;
  owner_e phase;
  step_e  step;
  logic   oe_int;
  logic [NUM_PORTS-1:0]   cap_fire;
  logic [DATA_W-1:0]      cap_out [NUM_PORTS];

  halfslot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_fast), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  halfslot_seq u_seq (
    .clk(clk_fast), .rst_n(rst_int_n), .phase_o(phase), .step_o(step),
    .bus_owner_o(bus_owner), .cycle_start_o(cycle_start)
  );

  halfslot_mem_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk(clk_fast), .rst_n(rst_int_n), .phase(phase), .step(step),
    .bus_owner(bus_owner), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vid_req(vid_req),
    .vid_addr(vid_addr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_oe(oe_int)
  );
  assign mem_oe = oe_int;

  always_comb begin
    cap_fire[PORT_CPU] = (step == STEP_ACCESS) && (phase == OWN_CPU) && oe_int;
    cap_fire[PORT_VID] = (step == STEP_ACCESS) && (phase == OWN_VID) && oe_int;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cap
    halfslot_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk_fast), .rst_n(rst_int_n), .fire(cap_fire[g]),
      .din(mem_rdata), .dout(cap_out[g])
    );
  end

  assign cpu_rdata = cap_out[PORT_CPU];
  assign vid_rdata = cap_out[PORT_VID];
endmodule

// File: tb/sim_halfslot_mem_arb.sv
module sim_halfslot_mem_arb;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we, vid_req;
  logic [AW-1:0] cpu_addr, vid_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, vid_rdata, mem_wdata, mem_rdata;
  logic cycle_start, bus_owner, mem_we, mem_oe;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  int checks = 0;
  int errors = 0;
  int mon_viol = 0;
  logic mon_on = 1'b0;
  logic prev_owner = 1'b0;
  logic obs_we [4];
  logic obs_oe [4];
  logic obs_own [4];

  always #5 clk = ~clk;

  halfslot_mem_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_fast(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vid_req(vid_req), .vid_addr(vid_addr), .vid_rdata(vid_rdata),
    .cycle_start(cycle_start), .bus_owner(bus_owner), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_oe(mem_oe),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_val(int i);
    return DW'((i * 37 + 5) & 255);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem_oe ? mem[mem_addr] : '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if ((mem_we || mem_oe) && bus_owner != prev_owner) mon_viol++;
      if (mem_we && bus_owner) mon_viol++;
      if (mem_we && mem_oe) mon_viol++;
    end
    prev_owner = bus_owner;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cycle(input logic cr, input logic cw, input int ca, input int cd,
                          input logic vr, input int va);
    cpu_req = cr; cpu_we = cw; cpu_addr = AW'(ca); cpu_wdata = DW'(cd);
    vid_req = vr; vid_addr = AW'(va);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      obs_we[k] = mem_we; obs_oe[k] = mem_oe; obs_own[k] = bus_owner;
    end
    if (cr && cw) shadow[ca] = DW'(cd);
    cpu_req = 0; vid_req = 0; cpu_we = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; cpu_req = 0; cpu_we = 0; vid_req = 0;
    cpu_addr = '0; vid_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_val(i);
    repeat (4) @(negedge clk);
    chk("R1", bus_owner, 0, "owner in reset");
    chk("R1", mem_we | mem_oe, 0, "enables in reset");
    chk("R1", cycle_start, 0, "cycle_start in reset");
    chk("R1", {cpu_rdata, vid_rdata}, 0, "holding regs in reset");
    rst_n = 1;
    begin
      int n = 0;
      int own_seen = 0;
      while (!cycle_start && n < 20) begin
        @(negedge clk); n++;
        if (!cycle_start) own_seen |= bus_owner;
      end
      chk("R1", n, 4, "fast cycles to first cycle_start");
      chk("R1", own_seen, 0, "owner before first video slot");
    end
    mon_on = 1;
  endtask

  task automatic t_sequence();
    int starts = 0;
    int own_bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      starts += cycle_start;
      if (bus_owner != ((k % 4 == 0 || k % 4 == 3) ? 1'b1 : 1'b0)) own_bad++;
      if (cycle_start != (k % 4 == 3)) own_bad++;
    end
    chk("R2", starts, 2, "cycle_start count in 8 fast cycles");
    chk("R2", own_bad, 0, "slot order mismatches");
  endtask

  task automatic t_write_read();
    do_cycle(1, 1, 12, 8'hA5, 0, 0);
    chk("R4", obs_we[2], 1, "we in CPU access");
    chk("R4", obs_we[0] | obs_we[1] | obs_we[3], 0, "we outside CPU access");
    chk("R3", obs_own[2], 0, "owner during CPU access");
    do_cycle(1, 1, 700, 8'h3C, 0, 0);
    do_cycle(1, 0, 12, 0, 0, 0);
    chk("R7", cpu_rdata, shadow[12], "cpu read addr 12");
    chk("R5", obs_oe[2], 1, "oe in CPU read access");
    do_cycle(1, 0, 700, 0, 0, 0);
    chk("R7", cpu_rdata, 8'h3C, "cpu read addr 700");
    do_cycle(1, 0, 999, 0, 0, 0);
    chk("R7", cpu_rdata, init_val(999), "cpu read untouched addr");
  endtask

  task automatic t_same_addr();
    logic [DW-1:0] old_v = shadow[40];
    do_cycle(1, 1, 40, 8'h77, 1, 40);
    chk("R6", vid_rdata, old_v, "video read same cycle as write");
    chk("R5", obs_oe[0], 1, "oe in video access");
    chk("R4", obs_we[0], 0, "no we in video access");
    do_cycle(0, 0, 0, 0, 1, 40);
    chk("R6", vid_rdata, 8'h77, "video read next cycle");
  endtask

  task automatic t_both_read();
    do_cycle(1, 0, 300, 0, 1, 301);
    chk("R9", cpu_rdata, shadow[300], "cpu read beside video read");
    chk("R9", vid_rdata, shadow[301], "video read beside cpu read");
    do_cycle(1, 1, 5, 8'h11, 1, 6);
    chk("R9", vid_rdata, shadow[6], "video read beside cpu write");
  endtask

  task automatic t_idle_hold();
    logic [DW-1:0] c0 = cpu_rdata;
    logic [DW-1:0] v0 = vid_rdata;
    do_cycle(0, 0, 0, 0, 0, 0);
    chk("R10", obs_we[0] | obs_we[1] | obs_we[2] | obs_we[3] |
               obs_oe[0] | obs_oe[1] | obs_oe[2] | obs_oe[3], 0, "enables when idle");
    chk("R8", {cpu_rdata, vid_rdata}, {c0, v0}, "holding regs when idle");
    do_cycle(1, 1, 9, 8'hEE, 0, 0);
    chk("R8", cpu_rdata, c0, "cpu holding reg after write");
    chk("R8", vid_rdata, v0, "video holding reg without request");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    while (!cycle_start) @(negedge clk);
    t_write_read();
    t_same_addr();
    t_both_read();
    t_idle_hold();
    chk("R3", mon_viol, 0, "monitor violations");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule